// File: doc/BRIEF.md
# Pattern-Driven Accumulator Bit Editor

This block holds one accumulator word and edits it under the control of a pattern word. Each request carries a 3-bit operation code, a pattern word and an insert word. The operation code selects how the pattern acts on the accumulator: forcing bits high, inverting bits, forcing bits low, keeping only some bits, marking the positions where the two words disagree, or replacing a bit field. A compare operation checks the accumulator against the pattern and leaves the accumulator as it is.

A request is taken on a rising clock edge where the valid strobe is high. The accumulator and a registered flag change on that same edge, so both are visible one edge after the request is presented. The flag normally reports whether the accumulator is all zeros. After a compare it reports whether the accumulator equalled the pattern. The accumulator starts from zero, and a selective set with a chosen pattern is the usual way to load it.

Top module: `bitedit_unit`

## Requirements
- R1: While reset is high, the accumulator is loaded with all zeros and the flag with 1 on each rising clock edge.
- R2: Operation code 0 (selective set) makes the new accumulator the old accumulator OR the pattern.
- R3: Operation code 1 (selective complement) makes the new accumulator the old accumulator XOR the pattern.
- R4: Operation code 2 (selective clear) makes the new accumulator the old accumulator AND the inverted pattern.
- R5: Operation code 3 (mask) makes the new accumulator the old accumulator AND the pattern.
- R6: Operation code 4 (clear-on-equal) makes each accumulator bit 0 where it matched the pattern bit and 1 where it differed.
- R7: Operation code 5 (insert) makes the new accumulator (old accumulator AND pattern) OR insert word.
- R8: Operation code 6 (compare) leaves the accumulator unchanged and sets the flag to 1 exactly when the accumulator equals the pattern.
- R9: Operation code 7 changes neither the accumulator nor the flag.
- R10: On a clock edge where valid is low, neither the accumulator nor the flag changes, whatever the other inputs hold.
- R11: After operation codes 0 to 5, the flag is 1 exactly when the new accumulator is all zeros, and it changes on the same edge as the accumulator.
- R12: A result is visible on the outputs after the single rising edge that takes the request, and a request may be taken on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, sampled on each rising edge |
| req_op | input | 3 | Operation code, 0 to 7 |
| pat_b | input | WIDTH | Pattern word |
| ins_c | input | WIDTH | Insert word, used only by operation code 5 |
| acc_q | output | WIDTH | Registered accumulator |
| flag_q | output | 1 | Registered zero or equality flag |

## Verification
The properties assume that reset is high for at least one edge before any request and that the request inputs are stable around each rising edge. They do not assume that the operation code is defined while valid is low. The stimulus changes inputs only on falling edges. It keeps the operation code and the pattern set to active values during idle cycles, so the hold checks see inputs that would change the accumulator if the strobe were ignored. Requests run back to back as well as with gaps between them.

// File: rtl/bitedit_pkg.sv
package bitedit_pkg;
  localparam int OP_BITS = 3;

  typedef enum logic [OP_BITS-1:0] {
    OP_SET  = 3'd0,
    OP_FLIP = 3'd1,
    OP_CLR  = 3'd2,
    OP_KEEP = 3'd3,
    OP_DIFF = 3'd4,
    OP_INS  = 3'd5,
    OP_CMP  = 3'd6,
    OP_NOP  = 3'd7
  } edit_op_e;
endpackage

// File: rtl/bitedit_alu.sv
module bitedit_alu
  import bitedit_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]   acc,
  input  logic [WIDTH-1:0]   pat,
  input  logic [WIDTH-1:0]   ins,
  input  logic [OP_BITS-1:0] op,
  output logic [WIDTH-1:0]   nxt,
  output logic               wr_acc,
  output logic               wr_flag
);
  edit_op_e op_e;
  assign op_e = edit_op_e'(op);

  always_comb begin
    nxt     = acc;
    wr_acc  = 1'b1;
    wr_flag = 1'b1;
    unique case (op_e)
      OP_SET:  nxt = acc | pat;
      OP_FLIP: nxt = acc ^ pat;
      OP_CLR:  nxt = acc & ~pat;
      OP_KEEP: nxt = acc & pat;
      OP_DIFF: nxt = acc ^ pat;
      OP_INS:  nxt = (acc & pat) | ins;
      OP_CMP:  wr_acc = 1'b0;
      default: begin
        wr_acc  = 1'b0;
        wr_flag = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bitedit_flag.sv
module bitedit_flag
  import bitedit_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [OP_BITS-1:0] op,
  input  logic [WIDTH-1:0]   acc,
  input  logic [WIDTH-1:0]   pat,
  input  logic [WIDTH-1:0]   nxt,
  output logic               flag_nxt
);
  logic is_cmp;
  assign is_cmp   = (edit_op_e'(op) == OP_CMP);
  assign flag_nxt = is_cmp ? (acc == pat) : (nxt == '0);
endmodule

// File: rtl/bitedit_unit.sv
module bitedit_unit
  import bitedit_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [2:0]          req_op,
  input  logic [WIDTH-1:0]    pat_b,
  input  logic [WIDTH-1:0]    ins_c,
  output logic [WIDTH-1:0]    acc_q,
  output logic                flag_q
);
  logic [WIDTH-1:0] nxt;
  logic             wr_acc, wr_flag, flag_nxt;

  bitedit_alu #(.WIDTH(WIDTH)) u_alu (
    .acc(acc_q), .pat(pat_b), .ins(ins_c), .op(req_op),
    .nxt(nxt), .wr_acc(wr_acc), .wr_flag(wr_flag)
  );

  bitedit_flag #(.WIDTH(WIDTH)) u_flag (
    .op(req_op), .acc(acc_q), .pat(pat_b), .nxt(nxt), .flag_nxt(flag_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      flag_q <= 1'b1;
    end else if (req_valid) begin
      if (wr_acc)  acc_q  <= nxt;
      if (wr_flag) flag_q <= flag_nxt;
    end
  end

  // R1 reset values
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && flag_q);

  // R10 idle edges hold state
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(acc_q) && $stable(flag_q));

  // R2 selective set
  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd0) |=> acc_q == ($past(acc_q) | $past(pat_b)));

  // R5 mask
  assert_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd3) |=> acc_q == ($past(acc_q) & $past(pat_b)));

  // R7 insert
  assert_insert_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd5) |=>
      acc_q == (($past(acc_q) & $past(pat_b)) | $past(ins_c)));

  // R8 compare keeps accumulator, flag reports equality
  assert_compare_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd6) |=>
      $stable(acc_q) && (flag_q == ($past(acc_q) == $past(pat_b))));

  // R9 no-op code
  assert_nop_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd7) |=> $stable(acc_q) && $stable(flag_q));

  // R11 flag follows the new accumulator
  assert_zero_flag_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op <= 3'd5) |=> flag_q == (acc_q == '0));
endmodule

// File: tb/test_bitedit_unit.sv
`timescale 1ns/1ps
module test_bitedit_unit;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [2:0]   req_op = 3'd0;
  logic [W-1:0] pat_b = '0;
  logic [W-1:0] ins_c = '0;
  logic [W-1:0] acc_q;
  logic         flag_q;

  always #2.5 clk = ~clk;

  bitedit_unit #(.WIDTH(W)) i_bitedit_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .pat_b(pat_b), .ins_c(ins_c), .acc_q(acc_q), .flag_q(flag_q)
  );

  typedef struct {
    logic [W-1:0] acc;
    logic         flag;
    string        tag;
  } exp_t;

  exp_t         sbq[$];
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;
  logic [W-1:0] m_acc = '0;
  logic         m_flag = 1'b1;

  task automatic check(input string tag, input logic [W-1:0] a, input logic f,
                       input logic [W-1:0] ea, input logic ef);
    total++;
    if (a !== ea || f !== ef) begin
      bad++;
      $display("FAIL %s: acc=%h flag=%b expected acc=%h flag=%b", tag, a, f, ea, ef);
    end
  endtask

  // driver: drive on falling edge, push expected state after the next rising edge
  task automatic drive(input string tag, input logic v, input logic [2:0] op,
                       input logic [W-1:0] b, input logic [W-1:0] c);
    exp_t e;
    @(negedge clk);
    req_valid = v; req_op = op; pat_b = b; ins_c = c;
    if (v) begin
      case (op)
        3'd0: m_acc = m_acc | b;
        3'd1: m_acc = m_acc ^ b;
        3'd2: m_acc = m_acc & ~b;
        3'd3: m_acc = m_acc & b;
        3'd4: m_acc = m_acc ^ b;
        3'd5: m_acc = (m_acc & b) | c;
        default: ;
      endcase
      if (op == 3'd6)     m_flag = (m_acc == b);
      else if (op != 3'd7) m_flag = (m_acc == '0);
    end
    e.acc = m_acc; e.flag = m_flag; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compare one item per rising edge, 1 ns after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check(e.tag, acc_q, flag_q, e.acc, e.flag);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", acc_q, flag_q, '0, 1'b1);
    @(negedge clk);
    rst = 1'b0;
    // R2 load 000C, then set with 000A -> 000E
    drive("R2 load",       1, 3'd0, 16'h000C, 16'h0);
    drive("R2 set",        1, 3'd0, 16'h000A, 16'h0);
    drive("R5 mask zero",  1, 3'd3, 16'h0000, 16'h0);
    drive("R11 zero after mask", 1, 3'd0, 16'h000C, 16'h0);
    drive("R3 complement", 1, 3'd1, 16'h000A, 16'h0);
    drive("R5 mask clear", 1, 3'd3, 16'h0000, 16'h0);
    drive("R4 reload",     1, 3'd0, 16'h000C, 16'h0);
    drive("R4 clear",      1, 3'd2, 16'h000A, 16'h0);
    drive("R5 mask",       1, 3'd3, 16'hFF0F, 16'h0);
    drive("R10 idle",      0, 3'd0, 16'hFFFF, 16'hFFFF);
    drive("R10 idle ins",  0, 3'd5, 16'h0000, 16'h5555);
    drive("R6 prep",       1, 3'd0, 16'h3C3C, 16'h0);
    drive("R6 diff",       1, 3'd4, 16'h0FF0, 16'h0);
    drive("R11 diff equal", 1, 3'd4, 16'h33CC, 16'h0);
    drive("R7 prep",       1, 3'd0, 16'hD8B1, 16'h0);
    drive("R7 insert",     1, 3'd5, 16'hFFF0, 16'h000A);
    drive("R8 compare ne", 1, 3'd6, 16'hD8B1, 16'h0);
    drive("R8 compare eq", 1, 3'd6, 16'hD8BA, 16'h0);
    drive("R9 nop",        1, 3'd7, 16'h0000, 16'hFFFF);
    drive("R8 compare ne2", 1, 3'd6, 16'h0000, 16'h0);
    drive("R9 nop keeps flag", 1, 3'd7, 16'hD8BA, 16'h1234);
    drive("R12 b2b set",   1, 3'd0, 16'h8000, 16'h0);
    drive("R12 b2b flip",  1, 3'd1, 16'hFFFF, 16'h0);
    drive("R12 b2b ins",   1, 3'd5, 16'h0000, 16'h0000);
    drive("R10 idle after", 0, 3'd0, 16'hFFFF, 16'h0);
    repeat (3) @(posedge clk);
    #2;
    if (sbq.size() != 0) begin
      bad++; total++;
      $display("FAIL R12: %0d items left in scoreboard, expected 0", sbq.size());
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule